// File: doc/BRIEF.md
# Serial Peripheral Target Front End with Pause

This block is the bus-facing half of a serial memory target. It watches the chip-select, serial clock, serial data-in and pause inputs, oversamples them with the core clock, and turns the serial stream into whole bytes for the core. Each byte comes with a one-cycle strobe, and a flag marks the opening (opcode) byte of a selection. In the other direction it takes a byte from the core at every byte boundary and shifts it out most significant bit first, together with an output-enable that tells the pad when to drive.

Clock idle low (mode 0) and clock idle high (mode 3) both work without configuration. Input bits are taken on the rising clock edge and output bits move on the falling edge. A pause input freezes the transfer at a clock-low point without losing its position. Releasing the pause resumes the same byte. Raising chip-select abandons any partial byte and any pause.

Top module: `spi_tgt_front`

## Requirements
- R1: Bytes are received correctly whether the serial clock idles low (mode 0) or high (mode 3) at selection.
- R2: Serial input is taken on rising clock edges, most significant bit first, and `rx_valid` pulses for exactly one core cycle after the 8th bit with the byte on `rx_byte`.
- R3: `rx_first` is 1 with the first byte of a selection and 0 with every later byte of it.
- R4: On the falling clock edge that follows a byte boundary, `tx_byte` is loaded and bit 7 appears on `sdo`. Each later falling edge moves the next lower bit onto `sdo`.
- R5: `sdo_oe` is 0 while chip-select is high or `tx_en` is 0.
- R6: A pause request (`hold_n` low) that arrives while the clock is low sets `paused` without waiting for a clock edge.
- R7: A pause request that arrives while the clock is high takes effect only when the clock next goes low.
- R8: Releasing the pause while the clock is low clears `paused` at once. Releasing it while the clock is high clears `paused` only when the clock next goes low.
- R9: While paused, clock and data-in transitions neither advance nor alter the byte in progress, and `sdo_oe` is 0.
- R10: Raising chip-select mid-byte discards the partial byte with no strobe, and the next selection starts counting from bit 0 with `rx_first` set.
- R11: Raising chip-select while paused clears `paused` and restarts the transfer logic.
- R12: After reset, `sdo_oe`, `rx_valid` and `paused` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the bus |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| tx_byte | input | 8 | Next byte to send, taken at each byte boundary |
| tx_en | input | 1 | Core allows the output to be driven |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Pad drive enable for `sdo` (0 = high impedance) |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_first | output | 1 | Marks the opening byte of a selection |
| rx_byte | output | 8 | Received byte |
| paused | output | 1 | Transfer is frozen by the pause input |

## Verification
The bench builds the block with two synchroniser stages and an 8-bit byte, the default values. With these defaults one serial half-period of eight core cycles covers the three-cycle path from pin to register, so every edge is seen one at a time. They also make it possible to place the pause request on either side of a clock edge and watch the deferred entry and exit. Each serial edge then shows up as a clean single event, and a bit sampled on `sdo` belongs to exactly one falling edge.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    typedef enum logic [1:0] {
        HS_RUN,
        HS_ENTER_WAIT,
        HS_HELD,
        HS_EXIT_WAIT
    } hold_st_e;

    typedef struct packed {
        logic  cs_n;
        logic  sck;
        logic  hold_n;
        logic  sdi;
    } pins_t;

    function automatic logic st_frozen(hold_st_e st);
        return (st == HS_HELD) || (st == HS_EXIT_WAIT);
    endfunction

    function automatic byte_t shift_in(byte_t cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync
    import spi_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_in,
    output pins_t pins_s,
    output logic  sck_rise,
    output logic  sck_fall
);
    localparam pins_t IDLE = '{cs_n: 1'b1, sck: 1'b0, hold_n: 1'b1, sdi: 1'b0};

    pins_t stg [STAGES];
    logic  sck_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[g] <= IDLE;
                end else if (g == 0) begin
                    stg[g] <= pins_in;
                end else begin
                    stg[g] <= stg[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= stg[STAGES-1].sck;
    end

    assign pins_s   = stg[STAGES-1];
    assign sck_rise = pins_s.sck & ~sck_q;
    assign sck_fall = ~pins_s.sck & sck_q;

endmodule

// File: rtl/spi_tgt_hold.sv
module spi_tgt_hold
    import spi_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sck_s,
    input  logic hold_s,
    output logic go,
    output logic paused
);
    hold_st_e st, st_nx;

    always_comb begin
        st_nx = st;
        if (!sel) begin
            st_nx = HS_RUN;
        end else begin
            unique case (st)
                HS_RUN:        if (!hold_s) st_nx = sck_s ? HS_ENTER_WAIT : HS_HELD;
                HS_ENTER_WAIT: if (hold_s)  st_nx = HS_RUN;
                               else if (!sck_s) st_nx = HS_HELD;
                HS_HELD:       if (hold_s)  st_nx = sck_s ? HS_EXIT_WAIT : HS_RUN;
                HS_EXIT_WAIT:  if (!hold_s) st_nx = HS_HELD;
                               else if (!sck_s) st_nx = HS_RUN;
                default:       st_nx = HS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= HS_RUN;
        else     st <= st_nx;
    end

    assign go     = sel && (st == HS_RUN) && hold_s;
    assign paused = st_frozen(st);

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
    import spi_tgt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  go,
    input  logic  held,
    input  logic  rise,
    input  logic  fall,
    input  logic  sdi_s,
    input  byte_t tx_byte,
    input  logic  tx_en,
    output logic  rx_valid,
    output logic  rx_first,
    output byte_t rx_byte,
    output logic  sdo,
    output logic  sdo_oe
);
    bitcnt_t cnt;
    byte_t   rx_sh, tx_sh, rx_nx;
    logic    first_pend;

    assign rx_nx = shift_in(rx_sh, sdi_s);

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            cnt        <= '0;
            first_pend <= 1'b1;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rx_valid   <= 1'b0;
            rx_first   <= 1'b0;
            rx_byte    <= '0;
            sdo_oe     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            sdo_oe   <= tx_en && !held;
            if (rise && go) begin
                rx_sh <= rx_nx;
                if (cnt == bitcnt_t'(BYTE_W-1)) begin
                    cnt        <= '0;
                    rx_valid   <= 1'b1;
                    rx_byte    <= rx_nx;
                    rx_first   <= first_pend;
                    first_pend <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (fall && go) begin
                if (cnt == '0) tx_sh <= tx_byte;
                else           tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign sdo = tx_sh[BYTE_W-1];

endmodule

// File: rtl/spi_tgt_front.sv
module spi_tgt_front
    import spi_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        sdi,
    input  logic        hold_n,
    input  logic [7:0]  tx_byte,
    input  logic        tx_en,
    output logic        sdo,
    output logic        sdo_oe,
    output logic        rx_valid,
    output logic        rx_first,
    output logic [7:0]  rx_byte,
    output logic        paused
);
    pins_t pins_in, pins_s;
    logic  sck_rise, sck_fall, go, cs_s;

    assign pins_in = '{cs_n: cs_n, sck: sck, hold_n: hold_n, sdi: sdi};
    assign cs_s    = pins_s.cs_n;

    spi_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pins_in(pins_in), .pins_s(pins_s),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    spi_tgt_hold u_hold (
        .clk(clk), .rst(rst), .sel(!cs_s), .sck_s(pins_s.sck),
        .hold_s(pins_s.hold_n), .go(go), .paused(paused)
    );

    spi_tgt_shift u_shift (
        .clk(clk), .rst(rst), .sel(!cs_s), .go(go), .held(paused),
        .rise(sck_rise), .fall(sck_fall), .sdi_s(pins_s.sdi),
        .tx_byte(tx_byte), .tx_en(tx_en), .rx_valid(rx_valid),
        .rx_first(rx_first), .rx_byte(rx_byte), .sdo(sdo), .sdo_oe(sdo_oe)
    );

endmodule

// File: rtl/spi_tgt_front_chk.sv
module spi_tgt_front_chk (
    input logic clk,
    input logic rst,
    input logic cs_s,
    input logic paused,
    input logic sdo,
    input logic sdo_oe,
    input logic rx_valid
);
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r9_no_drive_held: assert property (@(posedge clk) disable iff (rst)
        (paused && $past(paused)) |-> !sdo_oe);

    a_r9_sdo_frozen: assert property (@(posedge clk) disable iff (rst)
        (paused && $past(paused)) |-> $stable(sdo));

    a_r11_deselect_unpauses: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !paused);

    a_r10_no_strobe_deselected: assert property (@(posedge clk) disable iff (rst)
        $past(cs_s) |-> !rx_valid);

    a_r5_no_drive_deselected: assert property (@(posedge clk) disable iff (rst)
        $past(cs_s) |-> !sdo_oe);

endmodule

bind spi_tgt_front spi_tgt_front_chk u_chk (
    .clk(clk), .rst(rst), .cs_s(cs_s), .paused(paused),
    .sdo(sdo), .sdo_oe(sdo_oe), .rx_valid(rx_valid)
);

// File: tb/spi_tgt_front_bench.sv
module spi_tgt_front_bench;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;
    localparam int NV    = 6;
    // {mode3, opcode byte, data byte, tx byte}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h9F, 8'h00, 8'hC3},
        {1'b1, 8'h03, 8'hFF, 8'h5A},
        {1'b0, 8'hA5, 8'h81, 8'h01},
        {1'b1, 8'h00, 8'h7E, 8'h80},
        {1'b0, 8'hFF, 8'h3C, 8'hFF},
        {1'b1, 8'h6B, 8'hD2, 8'h00}
    };

    logic clk = 0, rst = 1, cs_n = 1, sck = 0, sdi = 0, hold_n = 1, tx_en = 0;
    logic [7:0] tx_byte = 0;
    logic sdo, sdo_oe, rx_valid, rx_first, paused;
    logic [7:0] rx_byte;
    int errors = 0, checks = 0, n_rx = 0;
    bit done = 0;
    logic [7:0] log_b [256];
    logic       log_f [256];

    always #(CLK_P/2) clk = ~clk;

    spi_tgt_front u_spi_tgt_front (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
        .tx_byte(tx_byte), .tx_en(tx_en), .sdo(sdo), .sdo_oe(sdo_oe),
        .rx_valid(rx_valid), .rx_first(rx_first), .rx_byte(rx_byte), .paused(paused)
    );

    always @(negedge clk) if (rx_valid) begin
        log_b[n_rx & 255] = rx_byte;
        log_f[n_rx & 255] = rx_first;
        n_rx++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sck = 0; sdi = b; hw(HALF);
        sck = 1; hw(HALF);
    endtask

    task automatic finish_sel(input logic m3);
        if (!m3) begin sck = 0; hw(HALF); end
        cs_n = 1; hw(2*HALF);
    endtask

    task automatic xfer(input logic m3, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] tx, output logic [7:0] got);
        sck = m3; tx_byte = tx; tx_en = 1; hw(HALF);
        cs_n = 0; hw(HALF);
        for (int i = 7; i >= 0; i--) send_bit(b0[i]);
        for (int i = 7; i >= 0; i--) begin
            sck = 0; sdi = b1[i]; hw(HALF);
            got[i] = sdo;
            sck = 1; hw(HALF);
        end
        finish_sel(m3);
    endtask

    task automatic expect_one(input logic [7:0] b, input int base, input string req);
        chk(n_rx - base == 1, req, n_rx - base, 1);
        chk(log_b[base & 255] == b && log_f[base & 255] == 1'b1, req,
            {log_f[base & 255], log_b[base & 255]}, {1'b1, b});
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int base;
        hw(4); rst = 0; hw(2);
        // R12 reset state
        chk(!sdo_oe && !rx_valid && !paused, "R12", {sdo_oe, rx_valid, paused}, 0);

        // R1 R2 R3 R4: table of two-byte transfers in both modes
        for (int v = 0; v < NV; v++) begin
            base = n_rx;
            xfer(VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], got);
            chk(n_rx - base == 2, "R1 R2 count", n_rx - base, 2);
            chk(log_b[base & 255] == VEC[v][23:16] && log_b[(base+1) & 255] == VEC[v][15:8],
                "R1 R2 bytes", {log_b[base & 255], log_b[(base+1) & 255]}, VEC[v][23:8]);
            chk(log_f[base & 255] == 1'b1 && log_f[(base+1) & 255] == 1'b0, "R3 first flag",
                {log_f[base & 255], log_f[(base+1) & 255]}, 2'b10);
            chk(got == VEC[v][7:0], "R4 sdo", got, VEC[v][7:0]);
        end

        // R5: no drive with tx_en low, or while deselected
        sck = 0; tx_en = 0; cs_n = 0; hw(2*HALF);
        chk(!sdo_oe, "R5 tx_en low", sdo_oe, 0);
        tx_en = 1; hw(HALF);
        chk(sdo_oe, "R5 tx_en high", sdo_oe, 1);
        cs_n = 1; hw(HALF);
        chk(!sdo_oe, "R5 deselected", sdo_oe, 0);

        // R6 R8 R9: pause with clock low, ignored edges, immediate release
        base = n_rx; cs_n = 0; hw(HALF);
        for (int i = 7; i >= 5; i--) send_bit(8'hA5 >> i);
        sck = 0; hw(HALF);
        hold_n = 0; hw(HALF);
        chk(paused, "R6 immediate pause", paused, 1);
        chk(!sdo_oe, "R9 no drive held", sdo_oe, 1'b0);
        for (int k = 0; k < 4; k++) begin
            sdi = k[0]; sck = 1; hw(HALF); sck = 0; hw(HALF);
        end
        hold_n = 1; hw(HALF);
        chk(!paused, "R8 immediate release", paused, 0);
        for (int i = 4; i >= 0; i--) send_bit(8'hA5 >> i);
        finish_sel(1'b0);
        expect_one(8'hA5, base, "R9 byte intact");

        // R7 R8: deferred entry and exit with clock high
        base = n_rx; cs_n = 0; hw(HALF);
        send_bit(1'b0); send_bit(1'b0);
        hold_n = 0; hw(HALF);
        chk(!paused, "R7 deferred entry", paused, 0);
        sck = 0; hw(HALF);
        chk(paused, "R7 entry at clock low", paused, 1);
        sck = 1; hw(HALF);
        hold_n = 1; hw(HALF);
        chk(paused, "R8 deferred exit", paused, 1);
        sck = 0; hw(HALF);
        chk(!paused, "R8 exit at clock low", paused, 0);
        for (int i = 5; i >= 0; i--) send_bit(8'h3C >> i);
        finish_sel(1'b0);
        expect_one(8'h3C, base, "R7 R8 byte intact");

        // R10: deselect mid-byte
        base = n_rx; cs_n = 0; hw(HALF);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        finish_sel(1'b0);
        chk(n_rx == base, "R10 partial dropped", n_rx - base, 0);
        xfer(1'b0, 8'h96, 8'h11, 8'h00, got);
        chk(log_b[base & 255] == 8'h96 && log_f[base & 255], "R10 restart",
            {log_f[base & 255], log_b[base & 255]}, 9'h196);

        // R11: deselect while paused
        base = n_rx; cs_n = 0; hw(HALF);
        send_bit(1'b1); send_bit(1'b0);
        sck = 0; hold_n = 0; hw(HALF);
        chk(paused, "R11 paused", paused, 1);
        cs_n = 1; hw(HALF);
        chk(!paused, "R11 deselect clears", paused, 0);
        hold_n = 1; hw(HALF);
        cs_n = 0; hw(HALF);
        for (int i = 7; i >= 0; i--) send_bit(8'h5A >> i);
        finish_sel(1'b0);
        expect_one(8'h5A, base, "R11 fresh byte");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule